// File: doc/BRIEF.md
# Two-Identity Serial Register Slave

This block is the two-wire serial front end of a supply-monitoring controller. It watches the clock and data lines of an I2C bus, which it samples in its own system clock domain. It answers on two device-type codes. One code opens a memory and configuration register space. The other code opens a space for commands, status and converter readout. Each byte written after the pointer byte appears on a register-file write port. Read data is taken from the register-file read port, using the current pointer.

A write transaction carries the pointer byte and then zero or more data bytes. Successive data bytes move only the low four pointer bits, so the writes stay inside one 16-byte page. A write to the memory space ends with a one-cycle commit strobe, and only at a valid stop condition. A read first sets the pointer with a write that has no data. A repeated start follows, and the read then streams bytes from the pointer. The pointer increments across its full width until the master withholds its acknowledge. A halt output tells the monitoring logic to pause. It rises when this slave acknowledges its own address and stays high until the next stop.

Top module: `i2c_dual_slave`

## Requirements
- R1: After reset, sda_oe_o, halt_o, commit_o and reg_we_o are all 0.
- R2: The address byte holds a type code in bits [7:4], a bus address in bits [3:1] and a direction bit in bit 0 (1 = read). The memory space (reg_space_o = 0) answers type 1010 when cfg_alt_id_i = 0, and type 1011 when cfg_alt_id_i = 1. The command space (reg_space_o = 1) always answers type 1001.
- R3: The slave acknowledges an address byte by pulling SDA low during the ninth clock. It does so only when the type code matches and the bus address equals {cfg_a2_sel_i ? a2_pin_i : 0, cfg_addr_i[1:0]}. For any other address byte it does not drive SDA until the next start.
- R4: halt_o rises with the slave's address acknowledge. It stays high until a stop is detected, and this includes the time after a read that ended with a not-acknowledge. It never rises for an address that does not match.
- R5: In a write, the first byte after the address loads the pointer. Each later byte is received MSB first and is acknowledged. Each such byte produces exactly one one-cycle reg_we_o pulse, with reg_addr_o equal to the pointer, reg_wdata_o equal to the byte, and reg_space_o equal to the addressed space.
- R6: After each written data byte, only pointer bits [3:0] increment, wrapping from 15 to 0. Bits above them stay unchanged.
- R7: commit_o pulses for one cycle on a stop only if at least one data byte was written to the memory space since the previous stop. A pointer-only write, a command-space write and a stop in the middle of a transfer with no data byte produce no pulse.
- R8: In a read, each byte is driven MSB first from reg_rdata_i at the current pointer. After each byte the full pointer increments by one, which crosses page boundaries. The first byte after a pointer-only write followed by a repeated start comes from that pointer.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and does not drive it again before the next start.
- R10: A start in the middle of a byte resets bit reception, and the next eight bits are taken as a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cfg_alt_id_i | input | 1 | Memory space answers 1011 instead of 1010 |
| cfg_a2_sel_i | input | 1 | Bus address bit 2 taken from a2_pin_i when 1, else 0 |
| cfg_addr_i | input | 2 | Bus address bits [1:0] |
| a2_pin_i | input | 1 | External address strap |
| reg_space_o | output | 1 | Addressed space, 0 memory/config, 1 command/status |
| reg_addr_o | output | 8 | Register pointer |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data at reg_space_o/reg_addr_o |
| halt_o | output | 1 | Monitor halt, address acknowledge to stop |
| commit_o | output | 1 | Nonvolatile commit strobe |

## Verification
Two situations are the hardest to reach. The first is a write that crosses a page end, which shows whether the low pointer bits wrap while the upper bits hold. The second is a read that continues past the same page end. The stimulus writes six bytes starting at pointer 0x3C, and then reads four bytes starting at 0x3E. The written data must land at 0x30 and 0x31, and the read must return the unwritten bytes at 0x40 and 0x41. Every 7-bit address with a write direction is also swept under two strap settings. A start is placed halfway through a byte, and a stray read clock is given after a not-acknowledge.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;
  localparam logic [3:0] TYPE_MEM     = 4'b1010;
  localparam logic [3:0] TYPE_MEM_ALT = 4'b1011;
  localparam logic [3:0] TYPE_CMD     = 4'b1001;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] ff_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ff_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      ff_q   <= {ff_q[STAGES-2:0], line_i};
      prev_q <= ff_q[STAGES-1];
    end

  assign line_o = ff_q[STAGES-1];
  assign rise_o = line_o & ~prev_q;
  assign fall_o = ~line_o & prev_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_dual_pkg::*;
(
  input  logic       [7:0] byte_i,
  input  logic             alt_id_i,
  input  logic             a2_sel_i,
  input  logic             a2_i,
  input  logic       [1:0] cfg_addr_i,
  output logic             hit_o,
  output logic             cmd_o
);
  logic [2:0] own_bus;
  logic       mem_hit;

  assign own_bus = {a2_sel_i & a2_i, cfg_addr_i};
  assign mem_hit = (byte_i[7:4] == (alt_id_i ? TYPE_MEM_ALT : TYPE_MEM));
  assign cmd_o   = (byte_i[7:4] == TYPE_CMD);
  assign hit_o   = (mem_hit | cmd_o) & (byte_i[3:1] == own_bus);
endmodule

// File: rtl/i2c_page_ptr.sv
module i2c_page_ptr #(
  parameter int PTR_W  = 8,
  parameter int PAGE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             inc_page_i,
  input  logic             inc_lin_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, page_nxt;

  generate
    if (PAGE_W >= PTR_W) begin : g_flat
      assign page_nxt = ptr_q + 1'b1;
    end else begin : g_paged
      logic [PAGE_W-1:0] low_inc;
      assign low_inc  = ptr_q[PAGE_W-1:0] + 1'b1;
      assign page_nxt = {ptr_q[PTR_W-1:PAGE_W], low_inc};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         ptr_q <= '0;
    else if (load_i)     ptr_q <= load_val_i;
    else if (inc_page_i) ptr_q <= page_nxt;
    else if (inc_lin_i)  ptr_q <= ptr_q + 1'b1;

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave
  import i2c_dual_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int PAGE_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             cfg_alt_id_i,
  input  logic             cfg_a2_sel_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic             a2_pin_i,
  output logic             reg_space_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic             reg_we_o,
  output logic [7:0]       reg_wdata_o,
  input  logic [7:0]       reg_rdata_i,
  output logic             halt_o,
  output logic             commit_o
);
  localparam int BITS  = 8;
  localparam int CNT_W = $clog2(BITS);

  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_N)) i_sync (
      .clk_i, .rst_ni, .line_i(raw[g]),
      .line_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s     = lvl[0];
  assign sda_s     = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  // SDA edge while SCL stays high
  assign start_det = scl_s & ~scl_rise & fall[1];
  assign stop_det  = scl_s & ~scl_rise & rise[1];

  slv_state_e       state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [BITS-1:0]  sh_q, tx_q, byte_in;
  logic             phase_q, rw_q, space_q, nack_q, pend_q;
  logic             oe_q, halt_q, commit_q, we_q;
  logic [7:0]       wdata_q;
  logic             ld_q, inc_pg_q, inc_ln_q;
  logic [PTR_W-1:0] ld_val_q;
  logic             hit, is_cmd;

  assign byte_in = {sh_q[BITS-2:0], sda_s};

  i2c_addr_match i_match (
    .byte_i(byte_in), .alt_id_i(cfg_alt_id_i), .a2_sel_i(cfg_a2_sel_i),
    .a2_i(a2_pin_i), .cfg_addr_i, .hit_o(hit), .cmd_o(is_cmd)
  );

  i2c_page_ptr #(.PTR_W(PTR_W), .PAGE_W(PAGE_W)) i_ptr (
    .clk_i, .rst_ni, .load_i(ld_q), .load_val_i(ld_val_q),
    .inc_page_i(inc_pg_q), .inc_lin_i(inc_ln_q), .ptr_o(reg_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE; bit_cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      phase_q <= 1'b0; rw_q <= 1'b0; space_q <= 1'b0; nack_q <= 1'b0;
      pend_q <= 1'b0; oe_q <= 1'b0; halt_q <= 1'b0; commit_q <= 1'b0;
      we_q <= 1'b0; wdata_q <= '0; ld_q <= 1'b0; ld_val_q <= '0;
      inc_pg_q <= 1'b0; inc_ln_q <= 1'b0;
    end else begin
      commit_q <= 1'b0; we_q <= 1'b0; ld_q <= 1'b0;
      inc_pg_q <= 1'b0; inc_ln_q <= 1'b0;
      if (stop_det) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        halt_q   <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
      end else if (start_det) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        phase_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WDATA: if (scl_rise) begin
            sh_q      <= byte_in;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            phase_q   <= 1'b0;
            if (bit_cnt_q == CNT_W'(BITS-1)) begin
              if (state_q == ST_ADDR) begin
                if (hit) begin
                  state_q <= ST_ADDR_ACK;
                  rw_q    <= byte_in[0];
                  space_q <= is_cmd;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_PTR) begin
                ld_q     <= 1'b1;
                ld_val_q <= PTR_W'(byte_in);
                state_q  <= ST_PTR_ACK;
              end else begin
                we_q    <= 1'b1;
                wdata_q <= byte_in;
                pend_q  <= pend_q | ~space_q;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            if (!phase_q) begin
              phase_q <= 1'b1;
              oe_q    <= 1'b1;
              if (state_q == ST_ADDR_ACK) halt_q <= 1'b1;
            end else begin
              phase_q <= 1'b0;
              oe_q    <= 1'b0;
              if (state_q == ST_ADDR_ACK && rw_q) begin
                state_q <= ST_RDATA;
                tx_q    <= reg_rdata_i;
                oe_q    <= ~reg_rdata_i[BITS-1];
              end else if (state_q == ST_ADDR_ACK) begin
                state_q <= ST_PTR;
              end else begin
                inc_pg_q <= (state_q == ST_WDATA_ACK);
                state_q  <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == CNT_W'(BITS-1)) begin
                state_q <= ST_RDATA_ACK;
                phase_q <= 1'b0;
              end
            end else if (scl_fall) begin
              tx_q <= tx_q << 1;
              oe_q <= ~tx_q[BITS-2];
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) nack_q <= sda_s;
            else if (scl_fall) begin
              if (!phase_q) begin
                phase_q  <= 1'b1;
                oe_q     <= 1'b0;
                inc_ln_q <= 1'b1;
              end else if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_RDATA;
                tx_q    <= reg_rdata_i;
                oe_q    <= ~reg_rdata_i[BITS-1];
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign sda_oe_o    = oe_q;
  assign halt_o      = halt_q;
  assign commit_o    = commit_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_space_o = space_q;
endmodule

// File: rtl/i2c_dual_slave_chk.sv
module i2c_dual_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic halt_o,
  input logic commit_o,
  input logic reg_we_o
);
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R7
  AST_COMMIT_ENDS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (!halt_o && $past(halt_o))); // R4
  AST_WE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R5
  AST_WE_UNDER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> halt_o); // R4
  AST_DRIVE_UNDER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> halt_o); // R3
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R9
endmodule

bind i2c_dual_slave i2c_dual_slave_chk i_chk (.*);

// File: tb/test_i2c_dual_slave.sv
module test_i2c_dual_slave;
  localparam int Q = 5;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic scl = 1, m_low = 0;
  logic alt = 0, a2sel = 1, a2 = 1;
  logic [1:0] cfga = 2'b10;
  logic sda_oe, space, we, halt, commit;
  logic [7:0] addr, wdata, rdata;
  logic sda_line;
  assign sda_line = ~(m_low | sda_oe);

  logic [7:0] mem0 [256];
  logic [7:0] mem1 [256];
  int n_chk = 0, n_fail = 0, n_commit = 0, n_we = 0;
  bit done = 0;

  i2c_dual_slave i_i2c_dual_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .cfg_alt_id_i(alt), .cfg_a2_sel_i(a2sel), .cfg_addr_i(cfga), .a2_pin_i(a2),
    .reg_space_o(space), .reg_addr_o(addr), .reg_we_o(we), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata), .halt_o(halt), .commit_o(commit)
  );

  assign rdata = space ? mem1[addr] : mem0[addr];

  initial for (int i = 0; i < 256; i++) begin
    mem0[i] = 8'(i) ^ 8'h5A;
    mem1[i] = 8'(i) + 8'h30;
  end
  always @(posedge clk) begin
    if (we) begin
      n_we <= n_we + 1;
      if (space) mem1[addr] <= wdata; else mem0[addr] <= wdata;
    end
    if (commit) n_commit <= n_commit + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(posedge clk); endtask
  task automatic start_c();  // works from idle or with SCL low
    m_low = 0; wq(); scl = 1; wq(); m_low = 1; wq(); scl = 0; wq();
  endtask
  task automatic stop_c();
    m_low = 1; wq(); scl = 1; wq(); m_low = 0; wq(); wq();
  endtask
  task automatic put_bit(input logic b);
    m_low = ~b; wq(); scl = 1; wq(); wq(); scl = 0; wq();
  endtask
  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_low = 0; wq(); scl = 1; wq(); ack = ~sda_line; wq(); scl = 0; wq();
  endtask
  task automatic recv(input logic give_ack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1; wq(); b[i] = sda_line; wq(); scl = 0; wq();
    end
    m_low = give_ack; wq(); scl = 1; wq(); wq(); scl = 0; wq(); m_low = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int c0, w0;
    @(negedge clk);
    chk("R1 sda_oe", sda_oe, 0); chk("R1 halt", halt, 0);
    chk("R1 commit", commit, 0); chk("R1 we", we, 0);
    repeat (3) @(posedge clk); rst_n = 1; wq();

    // address sweep under two strap settings, write direction only
    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 1) begin alt = 1; a2sel = 0; a2 = 1; cfga = 2'b01; end
      for (int a = 0; a < 128; a++) begin
        logic [3:0] ty; logic [2:0] ba; logic exp;
        ty = 4'(a >> 3); ba = 3'(a);
        exp = ((ty == (alt ? 4'b1011 : 4'b1010)) || ty == 4'b1001) &&
              (ba == {a2sel & a2, cfga});
        c0 = n_commit;
        start_c(); send({7'(a), 1'b0}, ack);
        chk((ty == 4'b1001) ? "R2 cmd ack" : "R3 ack", ack, exp);
        chk("R4 halt after address", halt, exp);
        stop_c();
        chk("R4 halt cleared", halt, 0);
        chk("R7 no commit", n_commit, c0);
      end
    end
    alt = 0; a2sel = 1; a2 = 1; cfga = 2'b10;  // bus 110

    // page write from 0x3C, six bytes
    c0 = n_commit; w0 = n_we;
    start_c(); send(8'hAC, ack); send(8'h3C, ack);
    for (int k = 0; k < 6; k++) begin
      send(8'hC0 + 8'(k), ack);
      chk("R5 data ack", ack, 1);
    end
    chk("R7 no commit before stop", n_commit, c0);
    stop_c();
    chk("R7 commit at stop", n_commit, c0 + 1);
    chk("R5 write count", n_we, w0 + 6);
    for (int k = 0; k < 6; k++)
      chk("R6 page wrap data", mem0[{4'h3, 4'(12 + k)}], 8'hC0 + 8'(k));
    chk("R6 upper bits kept", mem0[8'h40], 8'h40 ^ 8'h5A);

    // read across the page end from 0x3E
    start_c(); send(8'hAC, ack); send(8'h3E, ack);
    start_c(); send(8'hAD, ack);
    chk("R8 read ack", ack, 1);
    recv(1, b); chk("R8 byte 3E", b, 8'hC2);
    recv(1, b); chk("R8 byte 3F", b, 8'hC3);
    recv(1, b); chk("R8 byte 40", b, 8'h40 ^ 8'h5A);
    recv(0, b); chk("R8 byte 41", b, 8'h41 ^ 8'h5A);
    chk("R9 released", sda_oe, 0);
    chk("R4 halt after nack", halt, 1);
    recv(0, b); chk("R9 no drive after nack", b, 8'hFF);
    c0 = n_commit;
    stop_c();
    chk("R4 halt at stop", halt, 0);
    chk("R7 read no commit", n_commit, c0);

    // pointer-only write then stop
    start_c(); send(8'hAC, ack); send(8'h20, ack); stop_c();
    chk("R7 pointer-only no commit", n_commit, c0);

    // command space write and read
    start_c(); send(8'h9C, ack); chk("R2 cmd space ack", ack, 1);
    send(8'h10, ack); send(8'h77, ack); stop_c();
    chk("R7 cmd write no commit", n_commit, c0);
    chk("R5 cmd space data", mem1[8'h10], 8'h77);
    chk("R5 mem space untouched", mem0[8'h10], 8'h10 ^ 8'h5A);
    start_c(); send(8'h9C, ack); send(8'h10, ack);
    start_c(); send(8'h9D, ack);
    recv(1, b); chk("R8 cmd byte 10", b, 8'h77);
    recv(0, b); chk("R8 cmd byte 11", b, 8'h41);
    stop_c();

    // start in the middle of a byte
    start_c();
    put_bit(1); put_bit(0); put_bit(1); put_bit(0);
    start_c(); send(8'hAC, ack);
    chk("R10 restart mid-byte ack", ack, 1);
    stop_c();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule